// File: doc/BRIEF.md
# Memory-Paced Cycle Envelope Sequencer

This block divides every processor cycle into six timing envelopes, T0 through T5, and paces them against a core memory. It does not run freely. Three phase flip-flops (A, B, C) move only on a clock strobe. T0 is the rest envelope, in which the sequencer waits for the memory to report that read data is ready. Once data-ready arrives, the flops step through T1, T2 and T3 and then hold in T4. They stay in T4 until the memory signals that it has released the cycle. Release raises a one-strobe last-pulse envelope (T5), which closes the cycle and returns the sequencer to T0. Because of this, the cycle length follows the memory cycle time.

The block also drives the memory request.
- **Overlapped mode** (`need_mem_i` high): the cycle before or after the current one uses memory. The request is launched as soon as the current memory cycle is released, so memory accesses can chain back to back.
- **Deferred mode** (`need_mem_i` low): the request is held off until the sequencer sits in T0.

In both modes the request stays up until data-ready is seen and is then dropped, so each memory cycle receives exactly one request. A data-ready or release strobe that arrives before the sequencer can act on it is remembered until it is used.

Top module: `tenv_top`

## Requirements
- R1: While reset is high and on the first cycle after it, the phase flops are all clear, envelope T0 is the only active envelope, and memory request and last pulse are low.
- R2: Exactly one bit of `env_o` is high at all times; bit k marks envelope Tk. The phase flops {A,B,C} read 000 in T0, 100 in T1, 110 in T2, 111 in T3, and 101 in both T4 and T5. T5 is the last-pulse envelope, shown on `lastp_o`.
- R3: The phase flops change only on a strobe cycle. A strobe taken in T0 while data-ready is present moves the sequencer to T1.
- R4: From T1 the sequencer advances T1 to T2 to T3 to T4, one envelope per strobe, with no memory input needed.
- R5: T4 is held until a memory release is present. The strobe that sees the release enters T5 for one strobe, and the following strobe returns to T0.
- R6: A release that arrives before T4 is remembered. It ends T4 at the first strobe in T4 with no further release pulse.
- R7: In deferred mode (`need_mem_i` = 0), a request is raised only on the clock after one spent in T0 with no request up and no data-ready pending. It is never raised in T1 to T5.
- R8: In overlapped mode (`need_mem_i` = 1), a release seen while no request is up raises the request on the next clock. No request is raised merely for being in T0.
- R9: Once raised, the request stays high until data-ready is sampled and falls on the following clock. A single memory cycle never sees two requests.
- R10: A data-ready that arrives outside T0 is remembered. It starts T1 at the first strobe in T0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_i | input | 1 | Synchronous active-high reset |
| dr_i | input | 1 | Memory data-ready strobe |
| rel_i | input | 1 | Memory release strobe |
| need_mem_i | input | 1 | High when an adjacent cycle uses memory (overlapped request mode) |
| env_o | output | 6 | One-hot envelope decode, bit k = Tk |
| ph_a_o | output | 1 | Phase flop A |
| ph_b_o | output | 1 | Phase flop B |
| ph_c_o | output | 1 | Phase flop C |
| mreq_o | output | 1 | Memory request |
| lastp_o | output | 1 | Last-pulse envelope |

## Verification
Two pairs of functions can act in the same clock.

The first pair is closing a cycle and launching the next request. In overlapped mode, a release arriving in T4 both raises the last pulse and starts a new request. The bench judges this by expecting T5 together with a high request on the same sampled cycle.

The second pair is starting a cycle and remembering a release. A data-ready and a release are driven together in T0. The bench expects T1 with the request dropped, and then expects T4 to end with no second release pulse.

A third case drives a data-ready during T5. The bench expects it to be held over and to start T1 one strobe after T0 is reached.

// File: rtl/tenv_pkg.sv
package tenv_pkg;

    typedef enum logic [2:0] {
        ENV_T0 = 3'd0,
        ENV_T1 = 3'd1,
        ENV_T2 = 3'd2,
        ENV_T3 = 3'd3,
        ENV_T4 = 3'd4,
        ENV_T5 = 3'd5
    } env_e;

    localparam int NUM_ENV = 6;

    typedef struct packed {
        logic a;
        logic b;
        logic c;
    } phase_t;

    localparam phase_t PH_REST = '{a: 1'b0, b: 1'b0, c: 1'b0};

    function automatic env_e env_decode(input phase_t p, input logic lp);
        env_e e;
        if (lp) begin
            e = ENV_T5;
        end else begin
            case ({p.a, p.b, p.c})
                3'b100:  e = ENV_T1;
                3'b110:  e = ENV_T2;
                3'b111:  e = ENV_T3;
                3'b101:  e = ENV_T4;
                default: e = ENV_T0;
            endcase
        end
        return e;
    endfunction

    function automatic logic phase_legal(input phase_t p);
        return ({p.a, p.b, p.c} != 3'b010) && ({p.a, p.b, p.c} != 3'b011)
            && ({p.a, p.b, p.c} != 3'b001);
    endfunction

endpackage

// File: rtl/tenv_strobe.sv
module tenv_strobe #(
    parameter int STRB_DIV = 1
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic stb_o
);
    localparam int CNT_W = (STRB_DIV > 1) ? $clog2(STRB_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STRB_DIV - 1);

    generate
        if (STRB_DIV <= 1) begin : g_every
            assign stb_o = 1'b1;
        end else begin : g_div
            logic [CNT_W-1:0] cnt_q;
            always_ff @(posedge clk_i) begin
                if (rst_i)                cnt_q <= '0;
                else if (cnt_q == CNT_LAST) cnt_q <= '0;
                else                      cnt_q <= cnt_q + 1'b1;
            end
            assign stb_o = (cnt_q == CNT_LAST);
        end
    endgenerate

endmodule

// File: rtl/tenv_phase.sv
module tenv_phase
    import tenv_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  logic   stb_i,
    input  logic   dr_i,
    input  logic   rel_i,
    output phase_t ph_o,
    output logic   lp_o,
    output env_e   env_o,
    output logic   dr_pend_o
);
    phase_t ph_q;
    logic   a_dly_q;
    logic   lp_q;
    logic   dr_seen_q;
    logic   rel_seen_q;

    env_e   env;
    logic   start;
    logic   close;

    assign env   = env_decode(ph_q, lp_q);
    assign start = stb_i && (env == ENV_T0) && (dr_i || dr_seen_q);
    assign close = stb_i && (env == ENV_T4) && (rel_i || rel_seen_q);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ph_q      <= PH_REST;
            a_dly_q   <= 1'b0;
            lp_q      <= 1'b0;
        end else if (stb_i) begin
            a_dly_q <= ph_q.a;
            // A: set by data-ready in rest, cleared by last pulse
            if (lp_q)       ph_q.a <= 1'b0;
            else if (start) ph_q.a <= 1'b1;
            // B: follows A while C is clear, dropped once C is set
            if (ph_q.c)                 ph_q.b <= 1'b0;
            else if (ph_q.a)            ph_q.b <= 1'b1;
            // C: set from delayed A while B is up, cleared by last pulse
            if (lp_q)                   ph_q.c <= 1'b0;
            else if (a_dly_q && ph_q.b) ph_q.c <= 1'b1;
            lp_q <= close;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            dr_seen_q  <= 1'b0;
            rel_seen_q <= 1'b0;
        end else begin
            dr_seen_q  <= start ? 1'b0 : (dr_seen_q || dr_i);
            rel_seen_q <= close ? 1'b0 : (rel_seen_q || rel_i);
        end
    end

    assign ph_o      = ph_q;
    assign lp_o      = lp_q;
    assign env_o     = env;
    assign dr_pend_o = dr_seen_q;

    a_r2_legal_phase: assert property (@(posedge clk_i) disable iff (rst_i)
        phase_legal(ph_q));
    a_r3_hold_off_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
        !stb_i |=> $stable(ph_q));
    a_r3_start_on_ready: assert property (@(posedge clk_i) disable iff (rst_i)
        (stb_i && env == ENV_T0 && dr_i) |=> (env == ENV_T1));
    a_r4_t1_to_t2: assert property (@(posedge clk_i) disable iff (rst_i)
        (stb_i && env == ENV_T1) |=> (env == ENV_T2));
    a_r4_t2_to_t3: assert property (@(posedge clk_i) disable iff (rst_i)
        (stb_i && env == ENV_T2) |=> (env == ENV_T3));
    a_r5_lp_returns_rest: assert property (@(posedge clk_i) disable iff (rst_i)
        (stb_i && lp_q) |=> (env == ENV_T0 && !lp_q));
    a_r5_t4_waits: assert property (@(posedge clk_i) disable iff (rst_i)
        (env == ENV_T4 && !rel_i && !rel_seen_q) |=> (env == ENV_T4));

endmodule

// File: rtl/tenv_req.sv
module tenv_req (
    input  logic clk_i,
    input  logic rst_i,
    input  logic need_mem_i,
    input  logic rel_i,
    input  logic dr_i,
    input  logic in_t0_i,
    input  logic dr_pend_i,
    output logic req_o
);
    logic req_q;
    logic raise_ovl;
    logic raise_dfr;

    assign raise_ovl = need_mem_i && rel_i && !req_q;
    assign raise_dfr = !need_mem_i && in_t0_i && !req_q && !dr_pend_i;

    always_ff @(posedge clk_i) begin
        if (rst_i)                      req_q <= 1'b0;
        else if (req_q && dr_i)         req_q <= 1'b0;
        else if (raise_ovl || raise_dfr) req_q <= 1'b1;
    end

    assign req_o = req_q;

    a_r9_drop_on_ready: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_q && dr_i) |=> !req_q);
    a_r9_hold_until_ready: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_q && !dr_i) |=> req_q);
    a_r8_launch_on_release: assert property (@(posedge clk_i) disable iff (rst_i)
        (need_mem_i && rel_i && !req_q) |=> req_q);
    a_r7_defer_to_t0: assert property (@(posedge clk_i) disable iff (rst_i)
        ($rose(req_q) && !$past(need_mem_i)) |-> $past(in_t0_i));

endmodule

// File: rtl/tenv_top.sv
module tenv_top
    import tenv_pkg::*;
#(
    parameter int STRB_DIV = 1
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                dr_i,
    input  logic                rel_i,
    input  logic                need_mem_i,
    output logic [NUM_ENV-1:0]  env_o,
    output logic                ph_a_o,
    output logic                ph_b_o,
    output logic                ph_c_o,
    output logic                mreq_o,
    output logic                lastp_o
);
    logic   stb;
    phase_t ph;
    logic   lp;
    env_e   env;
    logic   dr_pend;

    tenv_strobe #(.STRB_DIV(STRB_DIV)) u_strobe (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .stb_o (stb)
    );

    tenv_phase u_phase (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .stb_i     (stb),
        .dr_i      (dr_i),
        .rel_i     (rel_i),
        .ph_o      (ph),
        .lp_o      (lp),
        .env_o     (env),
        .dr_pend_o (dr_pend)
    );

    tenv_req u_req (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .need_mem_i (need_mem_i),
        .rel_i      (rel_i),
        .dr_i       (dr_i),
        .in_t0_i    (env == ENV_T0),
        .dr_pend_i  (dr_pend),
        .req_o      (mreq_o)
    );

    generate
        for (genvar k = 0; k < NUM_ENV; k++) begin : g_env
            assign env_o[k] = (env == env_e'(k));
        end
    endgenerate

    assign ph_a_o  = ph.a;
    assign ph_b_o  = ph.b;
    assign ph_c_o  = ph.c;
    assign lastp_o = lp;

    a_r2_env_onehot: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones(env_o) == 1);
    a_r2_lastp_is_t5: assert property (@(posedge clk_i) disable iff (rst_i)
        lastp_o |-> env_o[NUM_ENV-1]);

endmodule

// File: tb/tenv_top_tb_top.sv
`timescale 1ns/1ps
module tenv_top_tb_top;

    logic       clk_i = 1'b0;
    logic       rst_i = 1'b1;
    logic       dr_i = 1'b0;
    logic       rel_i = 1'b0;
    logic       need_mem_i = 1'b0;
    logic [5:0] env_o;
    logic       ph_a_o, ph_b_o, ph_c_o, mreq_o, lastp_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        int    env;
        logic  req;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    always #2.5 clk_i = ~clk_i;

    tenv_top dut_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .dr_i       (dr_i),
        .rel_i      (rel_i),
        .need_mem_i (need_mem_i),
        .env_o      (env_o),
        .ph_a_o     (ph_a_o),
        .ph_b_o     (ph_b_o),
        .ph_c_o     (ph_c_o),
        .mreq_o     (mreq_o),
        .lastp_o    (lastp_o)
    );

    function automatic logic [2:0] abc_of(input int e);
        case (e)
            1:       return 3'b100;
            2:       return 3'b110;
            3:       return 3'b111;
            4, 5:    return 3'b101;
            default: return 3'b000;
        endcase
    endfunction

    // driver: apply one clock of inputs and queue the state expected after that edge
    task automatic step(input logic r, input logic d, input logic l, input logic n,
                        input int e, input logic q, input string t);
        exp_t it;
        @(negedge clk_i);
        rst_i = r; dr_i = d; rel_i = l; need_mem_i = n;
        it.env = e; it.req = q; it.tag = t;
        exp_q.push_back(it);
        @(posedge clk_i);
    endtask

    // monitor: compare shortly after each edge
    initial begin
        forever begin
            @(posedge clk_i);
            #1;
            if (exp_q.size() > 0) begin
                exp_t it;
                logic [5:0] e_env;
                logic [2:0] e_abc;
                it    = exp_q.pop_front();
                e_env = 6'(1) << it.env;
                e_abc = abc_of(it.env);
                n_checks++;
                if (env_o !== e_env || {ph_a_o, ph_b_o, ph_c_o} !== e_abc ||
                    mreq_o !== it.req || lastp_o !== (it.env == 5)) begin
                    n_fail++;
                    $display("FAIL %s: env=%b abc=%b req=%b lp=%b expected env=%b abc=%b req=%b lp=%b",
                             it.tag, env_o, {ph_a_o, ph_b_o, ph_c_o}, mreq_o, lastp_o,
                             e_env, e_abc, it.req, (it.env == 5));
                end
            end
        end
    end

    initial begin
        // R1 reset state
        step(1, 0, 0, 0, 0, 0, "R1 reset");
        step(1, 1, 1, 1, 0, 0, "R1 reset ignores strobes");
        // deferred mode: request raised from T0
        step(0, 0, 0, 0, 0, 1, "R7 deferred request in T0");
        step(0, 1, 0, 0, 1, 0, "R3 data-ready starts T1, R9 request dropped");
        step(0, 0, 0, 0, 2, 0, "R4 T2");
        step(0, 0, 0, 0, 3, 0, "R4 T3");
        step(0, 0, 0, 0, 4, 0, "R4 T4");
        step(0, 0, 0, 0, 4, 0, "R5 T4 held without release");
        step(0, 0, 1, 0, 5, 0, "R5 release gives last pulse");
        step(0, 0, 0, 0, 0, 0, "R5 back to T0, R7 no request yet");
        step(0, 0, 0, 0, 0, 1, "R7 request after T0 seen");
        step(0, 0, 0, 0, 0, 1, "R9 request held");
        // data-ready and release in the same clock
        step(0, 1, 1, 0, 1, 0, "R3 start with early release");
        step(0, 0, 0, 0, 2, 0, "R4 T2");
        step(0, 0, 0, 0, 3, 0, "R4 T3");
        step(0, 0, 0, 0, 4, 0, "R4 T4");
        step(0, 0, 0, 0, 5, 0, "R6 remembered release ends T4");
        // overlapped mode
        step(0, 0, 0, 1, 0, 0, "R8 no request from T0 alone");
        step(0, 0, 0, 1, 0, 0, "R8 still no request");
        step(0, 1, 0, 1, 1, 0, "R3 T1");
        step(0, 0, 0, 1, 2, 0, "R4 T2");
        step(0, 0, 0, 1, 3, 0, "R4 T3");
        step(0, 0, 0, 1, 4, 0, "R4 T4");
        step(0, 0, 1, 1, 5, 1, "R8 release gives last pulse and request");
        step(0, 1, 0, 1, 0, 0, "R10 data-ready in T5 held, R9 dropped");
        step(0, 0, 0, 1, 1, 0, "R10 remembered data-ready starts T1");
        step(0, 0, 0, 1, 2, 0, "R4 T2");
        step(0, 0, 0, 1, 3, 0, "R4 T3");
        step(0, 0, 0, 1, 4, 0, "R4 T4");
        step(0, 0, 1, 0, 5, 0, "R7 no deferred request outside T0");
        step(0, 0, 0, 0, 0, 0, "R7 T0 reached, none yet");
        step(0, 0, 0, 0, 0, 1, "R7 deferred request");
        step(0, 1, 0, 0, 1, 0, "R9 drop on data-ready");
        step(0, 0, 0, 0, 2, 0, "R2 T2 encoding");
        // mid-run reset
        step(1, 0, 0, 0, 0, 0, "R1 reset mid-cycle");
        step(0, 0, 0, 1, 0, 0, "R1 first cycle after reset");
        @(negedge clk_i);
        dr_i = 0; rel_i = 0;
        repeat (3) @(posedge clk_i);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule